// File: doc/BRIEF.md
# Two-Level Page Translation Walker

This block turns 32-bit logical addresses into physical addresses. A logical address splits into three fields: a 10-bit outer index in bits 31:22, a 10-bit inner index in bits 21:12, and a 12-bit offset within a 4 KiB page. The upper 20 bits together form the page number.

An eight-entry, fully associative translation cache compares the page number of each request against every stored entry at once. On a hit, the stored frame number comes back in the next cycle and no memory access takes place. On a miss, the block walks a two-level table held in memory through a single read port that uses a request/grant handshake:
- The outer entry is located from a base-register input and the outer index.
- That entry supplies the page-aligned base of an inner table, which the inner index selects into.
- A valid inner entry supplies the frame number and is written into the cache.

A clear valid bit at either level raises a fault that names the level, and the cache is left as it was. The block only reads tables and never writes them. Only one translation is in flight at a time.

Top module: `ptw_top`

## Requirements
- R1: After reset, `busy`, `done`, `fault` and `mem_req` are low and the cache holds no valid entry, so the first request to any page walks memory.
- R2: The first read of a walk uses address `ptbr + laddr[31:22]*4`, where `ptbr` is the value sampled when the request was accepted.
- R3: Table entries are 32 bits, with the frame number in bits 31:12 and the valid flag in bit 0. After a valid outer entry, the second read address is `{outer_entry[31:12], laddr[21:12], 2'b00}`.
- R4: When the inner entry is valid, `done` pulses high for exactly one cycle, in the cycle after the inner grant. At the same time `paddr = {inner_entry[31:12], laddr[11:0]}`, and the translation is stored in the cache.
- R5: A request accepted on a cache hit raises `done` in the next cycle, with `paddr = {cached frame, laddr[11:0]}`. It makes no memory read, and `busy` stays low.
- R6: An outer entry with bit 0 clear raises a one-cycle `fault` with `fault_lvl = 0` in the cycle after its grant. No inner read is issued, and the cache contents are left unchanged.
- R7: An inner entry with bit 0 clear raises a one-cycle `fault` with `fault_lvl = 1` in the cycle after its grant, and the cache contents are left unchanged.
- R8: On a miss, `busy` is high from the cycle after acceptance until the cycle in which `done` or `fault` goes high. A `req_valid` while `busy` is high is ignored.
- R9: While `mem_req` is high and `mem_gnt` is low, `mem_req` stays high and `mem_addr` stays stable in the next cycle.
- R10: Successful walks fill the cache slots in round-robin order, starting from slot 0. The ninth fill after reset or a flush therefore evicts the first page that was filled.
- R11: A `flush` pulse clears every cache entry in one cycle. A request accepted in the same cycle as `flush` is treated as a miss, and a walk that completes in that cycle does not fill the cache.
- R12: `resp_acc` presents the access type of the request in the same cycle as its `done` or `fault`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all cache entries |
| req_valid | input | 1 | Request strobe, accepted when `busy` is low |
| req_laddr | input | 32 | Logical address |
| req_acc | input | 2 | Access type, returned with the result |
| ptbr | input | 32 | Base address of the outer table |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse, translation valid |
| fault | output | 1 | One-cycle pulse, invalid entry |
| fault_lvl | output | 1 | Level of the fault: 0 outer, 1 inner |
| paddr | output | 32 | Physical address |
| resp_acc | output | 2 | Access type of the finished request |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 32 | Table read address |
| mem_gnt | input | 1 | Read grant; `mem_rdata` is valid in this cycle |
| mem_rdata | input | 32 | Table entry data |

## Verification
The timing of each result is fixed:
- A hit is due one cycle after the accepting edge. The bench samples it at the first falling edge after acceptance and checks that the read counter is unchanged.
- A miss shows its outer read in the cycle after acceptance.
- The inner read follows one cycle after the outer grant.
- `done` or `fault` is due one cycle after the final grant.

Grant latency is varied between tests. The bench polls on falling edges, requires `busy` high on every cycle before the result, and checks the recorded read addresses against R2 and R3.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int LA_W  = 32;
    localparam int OFF_W = 12;
    localparam int P1_W  = 10;
    localparam int P2_W  = 10;
    localparam int VPN_W = P1_W + P2_W;
    localparam int PFN_W = LA_W - OFF_W;
    localparam int ACC_W = 2;

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PFN_W-1:0] pfn_t;

    typedef struct packed {
        logic [P1_W-1:0]  p1;
        logic [P2_W-1:0]  p2;
        logic [OFF_W-1:0] off;
    } laddr_t;

    typedef struct packed {
        pfn_t             pfn;
        logic [OFF_W-2:0] rsvd;
        logic             valid;
    } pte_t;

    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_OUTER = 2'd1,
        WS_INNER = 2'd2
    } wstate_e;

    localparam logic LVL_OUTER = 1'b0;
    localparam logic LVL_INNER = 1'b1;

    function automatic logic [LA_W-1:0] outer_addr(input logic [LA_W-1:0] base,
                                                   input logic [P1_W-1:0] idx);
        return base + {{(LA_W-P1_W-2){1'b0}}, idx, 2'b00};
    endfunction

    function automatic logic [LA_W-1:0] inner_addr(input pfn_t tbl,
                                                   input logic [P2_W-1:0] idx);
        return {tbl, idx, 2'b00};
    endfunction
endpackage

// File: rtl/ptw_rr.sv
module ptw_rr #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [IW-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (adv) begin
            if (ptr == IW'(N - 1)) ptr <= '0;
            else                   ptr <= ptr + 1'b1;
        end
    end
endmodule

// File: rtl/ptw_tcache.sv
module ptw_tcache
    import ptw_pkg::*;
#(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  vpn_t         lk_vpn,
    output logic         hit,
    output pfn_t         hit_pfn,
    input  logic         fill_en,
    input  vpn_t         fill_vpn,
    input  pfn_t         fill_pfn,
    output logic [N-1:0] vld_vec
);
    vpn_t          tag_q [N];
    pfn_t          pfn_q [N];
    logic [N-1:0]  match;
    logic [IW-1:0] vict;
    logic          do_fill;

    assign do_fill = fill_en && !flush;

    ptw_rr #(.N(N)) u_rr (
        .clk (clk),
        .rst (rst),
        .adv (do_fill),
        .ptr (vict)
    );

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_ent
            assign match[g] = vld_vec[g] && (tag_q[g] == lk_vpn);

            always_ff @(posedge clk) begin
                if (rst) begin
                    vld_vec[g] <= 1'b0;
                    tag_q[g]   <= '0;
                    pfn_q[g]   <= '0;
                end else if (flush) begin
                    vld_vec[g] <= 1'b0;
                end else if (do_fill && (vict == IW'(g))) begin
                    vld_vec[g] <= 1'b1;
                    tag_q[g]   <= fill_vpn;
                    pfn_q[g]   <= fill_pfn;
                end
            end
        end
    endgenerate

    always_comb begin
        hit_pfn = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) hit_pfn = hit_pfn | pfn_q[i];
        end
    end

    assign hit = |match;
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             req_valid,
    input  laddr_t           req_laddr,
    input  logic [ACC_W-1:0] req_acc,
    input  logic [LA_W-1:0]  ptbr,
    input  logic             hit,
    input  pfn_t             hit_pfn,
    input  logic             mem_gnt,
    input  logic [LA_W-1:0]  mem_rdata,
    output logic             busy,
    output logic             mem_req,
    output logic [LA_W-1:0]  mem_addr,
    output logic             done,
    output logic             fault,
    output logic             fault_lvl,
    output logic [LA_W-1:0]  paddr,
    output logic [ACC_W-1:0] resp_acc,
    output logic             fill_en,
    output vpn_t             fill_vpn,
    output pfn_t             fill_pfn
);
    wstate_e          state;
    laddr_t           la_q;
    logic [ACC_W-1:0] acc_q;
    logic [LA_W-1:0]  base_q;
    pfn_t             ibase_q;
    pte_t             pte;
    logic [OFF_W-2:0] unused_rsvd;

    assign pte         = pte_t'(mem_rdata);
    assign unused_rsvd = pte.rsvd;

    assign busy     = (state != WS_IDLE);
    assign mem_req  = busy;
    assign mem_addr = (state == WS_OUTER) ? outer_addr(base_q, la_q.p1)
                                          : inner_addr(ibase_q, la_q.p2);

    assign fill_en  = (state == WS_INNER) && mem_gnt && pte.valid;
    assign fill_vpn = {la_q.p1, la_q.p2};
    assign fill_pfn = pte.pfn;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= WS_IDLE;
            la_q      <= '0;
            acc_q     <= '0;
            base_q    <= '0;
            ibase_q   <= '0;
            done      <= 1'b0;
            fault     <= 1'b0;
            fault_lvl <= LVL_OUTER;
            paddr     <= '0;
            resp_acc  <= '0;
        end else begin
            done  <= 1'b0;
            fault <= 1'b0;
            case (state)
                WS_IDLE: begin
                    if (req_valid) begin
                        la_q   <= req_laddr;
                        acc_q  <= req_acc;
                        base_q <= ptbr;
                        if (hit && !flush) begin
                            done     <= 1'b1;
                            paddr    <= {hit_pfn, req_laddr.off};
                            resp_acc <= req_acc;
                        end else begin
                            state <= WS_OUTER;
                        end
                    end
                end
                WS_OUTER: begin
                    if (mem_gnt) begin
                        if (!pte.valid) begin
                            fault     <= 1'b1;
                            fault_lvl <= LVL_OUTER;
                            resp_acc  <= acc_q;
                            state     <= WS_IDLE;
                        end else begin
                            ibase_q <= pte.pfn;
                            state   <= WS_INNER;
                        end
                    end
                end
                WS_INNER: begin
                    if (mem_gnt) begin
                        resp_acc <= acc_q;
                        state    <= WS_IDLE;
                        if (!pte.valid) begin
                            fault     <= 1'b1;
                            fault_lvl <= LVL_INNER;
                        end else begin
                            done  <= 1'b1;
                            paddr <= {pte.pfn, la_q.off};
                        end
                    end
                end
                default: state <= WS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
#(
    parameter int NENT = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             req_valid,
    input  logic [LA_W-1:0]  req_laddr,
    input  logic [ACC_W-1:0] req_acc,
    input  logic [LA_W-1:0]  ptbr,
    output logic             busy,
    output logic             done,
    output logic             fault,
    output logic             fault_lvl,
    output logic [LA_W-1:0]  paddr,
    output logic [ACC_W-1:0] resp_acc,
    output logic             mem_req,
    output logic [LA_W-1:0]  mem_addr,
    input  logic             mem_gnt,
    input  logic [LA_W-1:0]  mem_rdata
);
    logic            hit;
    pfn_t            hit_pfn;
    logic            fill_en;
    vpn_t            fill_vpn;
    pfn_t            fill_pfn;
    logic [NENT-1:0] vld_vec;
    laddr_t          la;

    assign la = laddr_t'(req_laddr);

    ptw_tcache #(.N(NENT)) u_cache (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .lk_vpn   ({la.p1, la.p2}),
        .hit      (hit),
        .hit_pfn  (hit_pfn),
        .fill_en  (fill_en),
        .fill_vpn (fill_vpn),
        .fill_pfn (fill_pfn),
        .vld_vec  (vld_vec)
    );

    ptw_walker u_walk (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .req_valid (req_valid),
        .req_laddr (la),
        .req_acc   (req_acc),
        .ptbr      (ptbr),
        .hit       (hit),
        .hit_pfn   (hit_pfn),
        .mem_gnt   (mem_gnt),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .done      (done),
        .fault     (fault),
        .fault_lvl (fault_lvl),
        .paddr     (paddr),
        .resp_acc  (resp_acc),
        .fill_en   (fill_en),
        .fill_vpn  (fill_vpn),
        .fill_pfn  (fill_pfn)
    );
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         flush,
    input logic         req_valid,
    input logic         busy,
    input logic         hit,
    input logic         mem_req,
    input logic         mem_gnt,
    input logic [31:0]  mem_addr,
    input logic         done,
    input logic         fault,
    input logic [N-1:0] vld_vec
);
    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    // R5
    hit_fast_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && hit && !flush) |=> (done && !mem_req));

    // R11
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (vld_vec == '0));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_gnt) |=> (busy && !done && !fault));

    // R6
    excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && fault));

    // R10
    no_shrink_chk: assert property (@(posedge clk) disable iff (rst)
        !flush |=> ($countones(vld_vec) >= $past($countones(vld_vec))));

    // R1
    cause_chk: assert property (@(posedge clk) disable iff (rst)
        (done || fault) |-> $past(busy || req_valid));
endmodule

bind ptw_top ptw_chk #(.N(NENT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .req_valid (req_valid),
    .busy      (busy),
    .hit       (hit),
    .mem_req   (mem_req),
    .mem_gnt   (mem_gnt),
    .mem_addr  (mem_addr),
    .done      (done),
    .fault     (fault),
    .vld_vec   (vld_vec)
);

// File: tb/ptw_tb_top.sv
module ptw_tb_top;
    localparam logic [31:0] PTBR = 32'h0010_0000;
    localparam int          IPG  = 32'h200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_laddr = '0;
    logic [1:0]  req_acc = '0;
    logic        busy, done, fault, fault_lvl, mem_req, mem_gnt;
    logic [31:0] paddr, mem_addr, mem_rdata;
    logic [1:0]  resp_acc;

    int nchk = 0;
    int nbad = 0;
    int gnt_delay = 1;
    int bad_outer = -1;
    int bad_in_p1 = -1;
    int bad_in_p2 = -1;
    int nreads = 0;
    logic [31:0] addr_prev = '0, addr_last = '0;
    int hold_err = 0;
    logic        prev_wait = 1'b0;
    logic [31:0] prev_addr = '0;
    int gcnt = 0;
    int wd = 0;

    logic       r_done, r_fault, r_lvl;
    logic [31:0] r_paddr;
    logic [1:0] r_acc;
    int         r_cyc;
    int         r_busy_err;

    always #5 clk = ~clk;

    ptw_top dut_i (
        .clk(clk), .rst(rst), .flush(flush), .req_valid(req_valid),
        .req_laddr(req_laddr), .req_acc(req_acc), .ptbr(PTBR),
        .busy(busy), .done(done), .fault(fault), .fault_lvl(fault_lvl),
        .paddr(paddr), .resp_acc(resp_acc), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
    );

    function automatic logic [19:0] frame_of(int p1, int p2);
        return {p1[9:0], p2[9:0]} ^ 20'hA5A5A;
    endfunction

    function automatic logic [31:0] pte_of(logic [31:0] a);
        int pg, p1, p2;
        pg = int'(a[31:12]);
        if (pg == int'(PTBR[31:12])) begin
            p1 = int'(a[11:2]);
            return {20'(IPG + p1), 11'b0, (p1 != bad_outer)};
        end
        if (pg >= IPG && pg < IPG + 1024) begin
            p1 = pg - IPG;
            p2 = int'(a[11:2]);
            return {frame_of(p1, p2), 11'h7FF, !(p1 == bad_in_p1 && p2 == bad_in_p2)};
        end
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mem_gnt   <= 1'b0;
            mem_rdata <= '0;
            gcnt      <= 0;
        end else begin
            if (mem_gnt && mem_req) begin
                nreads    <= nreads + 1;
                addr_prev <= addr_last;
                addr_last <= mem_addr;
            end
            if (prev_wait && mem_req && mem_addr != prev_addr) hold_err <= hold_err + 1;
            prev_wait <= mem_req && !mem_gnt;
            prev_addr <= mem_addr;
            if (mem_gnt) begin
                mem_gnt <= 1'b0;
                gcnt    <= 0;
            end else if (mem_req) begin
                if (gcnt >= gnt_delay) begin
                    mem_gnt   <= 1'b1;
                    mem_rdata <= pte_of(mem_addr);
                end else begin
                    gcnt <= gcnt + 1;
                end
            end
        end
    end

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd == 100000) begin
            nbad = nbad + 1;
            nchk = nchk + 1;
            $display("FAIL R8 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk = nchk + 1;
        if (!ok) begin
            nbad = nbad + 1;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] la(int p1, int p2, int off);
        return {p1[9:0], p2[9:0], off[11:0]};
    endfunction

    // mode 0 plain, 1 intruding request while busy, 2 flush with the request
    task automatic translate(input logic [31:0] a, input logic [1:0] acc, input int mode);
        @(negedge clk);
        req_valid = 1'b1;
        req_laddr = a;
        req_acc   = acc;
        if (mode == 2) flush = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid  = 1'b0;
        flush      = 1'b0;
        r_cyc      = 1;
        r_busy_err = 0;
        while (!(done || fault) && r_cyc < 200) begin
            if (!busy) r_busy_err++;
            if (mode == 1 && r_cyc == 1) begin
                req_valid = 1'b1;
                req_laddr = la(777, 77, 7);
                req_acc   = ~acc;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            r_cyc++;
        end
        req_valid = 1'b0;
        r_done  = done;
        r_fault = fault;
        r_lvl   = fault_lvl;
        r_paddr = paddr;
        r_acc   = resp_acc;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!busy && !done && !fault && !mem_req, "R1 idle outputs",
            {busy, done, fault, mem_req}, 0);
    endtask

    task automatic t_miss();
        int n0;
        n0 = nreads;
        gnt_delay = 2;
        translate(la(3, 5, 12'h123), 2'd2, 0);
        chk(r_done && !r_fault, "R1 R4 first request walks", {r_done, r_fault}, 2);
        chk(nreads - n0 == 2, "R4 two reads", nreads - n0, 2);
        chk(addr_prev == PTBR + 12, "R2 outer addr", addr_prev, PTBR + 12);
        chk(addr_last == {20'(IPG + 3), 10'd5, 2'b00}, "R3 inner addr",
            addr_last, {20'(IPG + 3), 10'd5, 2'b00});
        chk(r_paddr == {frame_of(3, 5), 12'h123}, "R4 paddr", r_paddr, {frame_of(3, 5), 12'h123});
        chk(r_busy_err == 0, "R8 busy during walk", r_busy_err, 0);
        chk(r_acc == 2'd2, "R12 acc on done", r_acc, 2);
        @(negedge clk);
        chk(!done, "R4 done one cycle", done, 0);
    endtask

    task automatic t_hit();
        int n0;
        n0 = nreads;
        translate(la(3, 5, 12'hABC), 2'd1, 0);
        chk(r_cyc == 1 && r_done, "R5 hit latency", r_cyc, 1);
        chk(nreads == n0, "R5 no read on hit", nreads - n0, 0);
        chk(r_paddr == {frame_of(3, 5), 12'hABC}, "R5 hit paddr", r_paddr, {frame_of(3, 5), 12'hABC});
        chk(r_acc == 2'd1, "R12 acc on hit", r_acc, 1);
    endtask

    task automatic t_hold_ignore();
        int n0;
        n0 = nreads;
        gnt_delay = 4;
        translate(la(11, 900, 12'h004), 2'd3, 1);
        chk(r_done && r_paddr == {frame_of(11, 900), 12'h004}, "R8 intruder ignored",
            r_paddr, {frame_of(11, 900), 12'h004});
        chk(nreads - n0 == 2, "R8 intruder no reads", nreads - n0, 2);
        chk(hold_err == 0, "R9 addr held", hold_err, 0);
        repeat (3) @(negedge clk);
        chk(!busy && !done, "R8 intruder not queued", {busy, done}, 0);
    endtask

    task automatic t_fault_outer();
        int n0;
        gnt_delay = 1;
        bad_outer = 9;
        n0 = nreads;
        translate(la(9, 1, 0), 2'd0, 0);
        chk(r_fault && !r_done && r_lvl == 1'b0, "R6 outer fault", {r_fault, r_lvl}, 2);
        chk(nreads - n0 == 1, "R6 no inner read", nreads - n0, 1);
        chk(r_acc == 2'd0, "R12 acc on fault", r_acc, 0);
        @(negedge clk);
        chk(!fault, "R6 fault one cycle", fault, 0);
        n0 = nreads;
        translate(la(3, 5, 1), 2'd0, 0);
        chk(r_cyc == 1 && nreads == n0, "R6 cache kept after fault", r_cyc, 1);
        bad_outer = -1;
        n0 = nreads;
        translate(la(9, 1, 0), 2'd0, 0);
        chk(nreads - n0 == 2 && r_done, "R6 faulting page not cached", nreads - n0, 2);
    endtask

    task automatic t_fault_inner();
        int n0;
        bad_in_p1 = 4;
        bad_in_p2 = 6;
        n0 = nreads;
        translate(la(4, 6, 0), 2'd3, 0);
        chk(r_fault && r_lvl == 1'b1, "R7 inner fault", {r_fault, r_lvl}, 3);
        chk(nreads - n0 == 2, "R7 two reads", nreads - n0, 2);
        chk(r_acc == 2'd3, "R12 acc inner fault", r_acc, 3);
        bad_in_p1 = -1;
        n0 = nreads;
        translate(la(4, 6, 0), 2'd3, 0);
        chk(nreads - n0 == 2 && r_done, "R7 faulting page not cached", nreads - n0, 2);
    endtask

    task automatic t_rr();
        int n0;
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        for (int i = 0; i < 8; i++) translate(la(20, i, 0), 2'd0, 0);
        n0 = nreads;
        for (int i = 0; i < 8; i++) translate(la(20, i, 8), 2'd0, 0);
        chk(nreads == n0, "R10 eight entries resident", nreads - n0, 0);
        translate(la(20, 8, 0), 2'd0, 0);
        n0 = nreads;
        for (int i = 1; i < 9; i++) translate(la(20, i, 0), 2'd0, 0);
        chk(nreads == n0, "R10 survivors hit", nreads - n0, 0);
        translate(la(20, 0, 0), 2'd0, 0);
        chk(nreads - n0 == 2, "R10 oldest evicted", nreads - n0, 2);
    endtask

    task automatic t_flush();
        int n0;
        translate(la(30, 1, 0), 2'd0, 0);
        n0 = nreads;
        translate(la(30, 1, 4), 2'd0, 0);
        chk(nreads == n0, "R11 cached before flush", nreads - n0, 0);
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        n0 = nreads;
        translate(la(30, 1, 4), 2'd0, 0);
        chk(nreads - n0 == 2, "R11 miss after flush", nreads - n0, 2);
        n0 = nreads;
        translate(la(30, 1, 8), 2'd1, 2);
        chk(nreads - n0 == 2 && r_done, "R11 request with flush misses", nreads - n0, 2);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_miss();
        t_hit();
        t_hold_ignore();
        t_fault_outer();
        t_fault_inner();
        t_rr();
        t_flush();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule